// File: doc/BRIEF.md
# Associative Memory Road Matcher

This block finds candidate particle tracks ("roads") by matching a serial stream of coarse detector hits against a bank of stored road patterns. Each pattern keeps one hit address per detector layer. A hit arrives tagged with its layer. It is compared in the same cycle with that layer's word in every pattern, and any agreement sets a sticky match bit for that pattern and layer. The bit stays set until the event is cleared.

When the producer signals end of event, a vote stage counts the matched layers of each pattern. Every pattern whose count reaches a programmable layer threshold is marked as fired. The fired road indices are then streamed out, lowest index first, over a valid/ready handshake, and a last flag marks the final one. After the stream ends, or at once when no road fired, a done level is raised and held until the next event clear. Patterns and the threshold are written through simple strobed ports. These writes take effect only between events.

Top module: `road_matcher`

## Requirements
- R1: A hit on layer `l` sets the match bit of pattern `p`, layer `l` exactly when its address equals the word stored for pattern `p` at layer `l`. It never affects any other layer, and a layer index of `NUM_LAYERS` or above matches nothing.
- R2: Match bits are sticky. Once set, a bit stays set through later non-matching hits until `evt_clear`.
- R3: A hit presented in the same cycle as `evt_end` is included in that event's evaluation.
- R4: After `evt_end`, a pattern fires exactly when its number of set match bits is greater than or equal to the current threshold.
- R5: Fired road indices leave on `road_idx` in strictly ascending order, one per cycle in which `road_valid` and `road_ready` are both high. `road_idx` holds steady while `road_ready` is low, and `road_last` is high only on the final fired road.
- R6: `evt_done` goes high after the final fired road is accepted, or directly after evaluation when no road fired. In the second case `road_valid` never rises. `road_valid` and `evt_done` are never high together.
- R7: The threshold resets to `NUM_LAYERS`. A write on `thr_we` is applied only while idle (no hit since the last clear or reset) and only for values from 1 to `NUM_LAYERS`. Any other write is ignored.
- R8: A pattern write on `cfg_we` stores `cfg_addr` at (`cfg_pat`, `cfg_layer`) only while idle. Writes made after the first hit of an event are ignored.
- R9: `evt_clear` clears every match bit and abandons any evaluation or readout within one cycle. It takes priority over a hit or `evt_end` in the same cycle.
- R10: After reset, `road_valid` and `evt_done` are low and no match bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Pattern word write strobe |
| cfg_pat | input | PAT_IDX_W | Pattern index to write |
| cfg_layer | input | LAYER_IDX_W | Layer index to write |
| cfg_addr | input | ADDR_W | Hit address to store |
| thr_we | input | 1 | Threshold write strobe |
| thr_val | input | CNT_W | New layer threshold |
| evt_clear | input | 1 | Event clear: rearm all match bits |
| hit_valid | input | 1 | Hit strobe |
| hit_layer | input | LAYER_IDX_W | Layer of the hit |
| hit_addr | input | ADDR_W | Coarse address of the hit |
| evt_end | input | 1 | End of event, starts evaluation |
| road_valid | output | 1 | A fired road index is presented |
| road_ready | input | 1 | Consumer accepts the road index |
| road_idx | output | PAT_IDX_W | Index of the fired road |
| road_last | output | 1 | Presented road is the final one |
| evt_done | output | 1 | Readout finished, held until clear |

## Verification
The bench builds the block with 3 layers, 8 patterns and 3-bit addresses. With these sizes, each address picks exactly one pattern per layer, and every threshold from 1 to 3 can be swept over many events. A reference model in the bench computes the fired set and its ascending order, so multi-layer coincidences, empty events, out-of-range layers and the hit that coincides with end of event all occur often. Directed steps cover gated writes, a threshold write of zero, and clears during readout and alongside a hit.

// File: rtl/road_pkg.sv
// Shared types for the road matcher.
// Assumes: nothing beyond the SystemVerilog enum support.
package road_pkg;

    // Event sequencing states of the matcher.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,   // rearmed, no hit yet; writes allowed
        ST_COLLECT = 3'd1,   // hits of the current event being latched
        ST_EVAL    = 3'd2,   // one cycle: votes captured into readout
        ST_READ    = 3'd3,   // fired roads being streamed
        ST_DONE    = 3'd4    // readout finished, wait for clear
    } evt_state_t;

endpackage

// File: rtl/road_bank.sv
// Pattern storage and sticky match latches.
// One address word per pattern per layer. An accepted hit is compared in
// parallel against its own layer's word in every pattern, and an equal
// word sets that pattern/layer match bit until clr.
// Assumes: wr_en and hit_en are already gated by the caller's event state.
module road_bank #(
    parameter int NUM_LAYERS   = 6,
    parameter int NUM_PATTERNS = 64,
    parameter int ADDR_W       = 12,
    parameter int PAT_IDX_W    = 6,
    parameter int LAYER_IDX_W  = 3
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_en,
    input  logic [PAT_IDX_W-1:0]                     wr_pat,
    input  logic [LAYER_IDX_W-1:0]                   wr_layer,
    input  logic [ADDR_W-1:0]                        wr_addr,
    input  logic                                     hit_en,
    input  logic [LAYER_IDX_W-1:0]                   hit_layer,
    input  logic [ADDR_W-1:0]                        hit_addr,
    input  logic                                     clr,
    output logic [NUM_PATTERNS-1:0][NUM_LAYERS-1:0]  match_o
);

    for (genvar p = 0; p < NUM_PATTERNS; p++) begin : g_pat
        for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_lay
            logic [ADDR_W-1:0] word_q;
            logic              hit_q;
            logic              sel_wr;
            logic              eq_hit;

            assign sel_wr = wr_en && (wr_pat == PAT_IDX_W'(p))
                                  && (wr_layer == LAYER_IDX_W'(l));
            assign eq_hit = hit_en && (hit_layer == LAYER_IDX_W'(l))
                                   && (hit_addr == word_q);

            // Stored address word for this pattern and layer.
            always_ff @(posedge clk) begin
                if (!rst_n)      word_q <= '0;
                else if (sel_wr) word_q <= wr_addr;
            end

            // Sticky match bit, rearmed by clr.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) hit_q <= 1'b0;
                else if (eq_hit)   hit_q <= 1'b1;
            end

            assign match_o[p][l] = hit_q;
        end
    end

endmodule

// File: rtl/road_vote.sv
// Majority vote per pattern: counts the set match bits and fires when the
// count is greater than or equal to the threshold. Purely combinational.
// Assumes: thr is held stable while its result is captured.
module road_vote #(
    parameter int NUM_LAYERS   = 6,
    parameter int NUM_PATTERNS = 64,
    parameter int CNT_W        = 3
) (
    input  logic [NUM_PATTERNS-1:0][NUM_LAYERS-1:0] match_i,
    input  logic [CNT_W-1:0]                        thr,
    output logic [NUM_PATTERNS-1:0]                 fire_o
);

    for (genvar p = 0; p < NUM_PATTERNS; p++) begin : g_vote
        logic [CNT_W-1:0] cnt;

        // Population count of this pattern's matched layers.
        always_comb begin
            cnt = '0;
            for (int l = 0; l < NUM_LAYERS; l++) begin
                cnt = cnt + CNT_W'(match_i[p][l]);
            end
        end

        assign fire_o[p] = (cnt >= thr);
    end

endmodule

// File: rtl/road_readout.sv
// Holds the fired-road vector and presents the lowest pending index.
// Each pop retires that index; last is high when one road remains.
// Assumes: pop is only raised while any_o is high.
module road_readout #(
    parameter int NUM_PATTERNS = 64,
    parameter int PAT_IDX_W    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    load,
    input  logic [NUM_PATTERNS-1:0] load_vec,
    input  logic                    pop,
    output logic                    any_o,
    output logic                    last_o,
    output logic [PAT_IDX_W-1:0]    idx_o
);

    logic [NUM_PATTERNS-1:0] pend_q;
    logic [NUM_PATTERNS-1:0] rest;

    // Lowest set bit of the pending vector.
    always_comb begin
        idx_o = '0;
        for (int i = NUM_PATTERNS - 1; i >= 0; i--) begin
            if (pend_q[i]) idx_o = PAT_IDX_W'(i);
        end
    end

    assign rest   = pend_q & (pend_q - NUM_PATTERNS'(1));
    assign any_o  = |pend_q;
    assign last_o = any_o && (rest == '0);

    // Pending fired roads: loaded on evaluation, drained by pops.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pend_q <= '0;
        else if (load)     pend_q <= load_vec;
        else if (pop)      pend_q <= rest;
    end

endmodule

// File: rtl/road_matcher.sv
// Associative memory road matcher top.
// Sequences an event: idle -> collect hits -> evaluate -> stream fired
// roads -> done. It also holds the threshold register and gates pattern
// and threshold writes to the idle state.
// Assumes: the producer raises evt_clear before each new event.
module road_matcher #(
    parameter int NUM_LAYERS   = 6,
    parameter int NUM_PATTERNS = 64,
    parameter int ADDR_W       = 12,
    localparam int PAT_IDX_W   = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1,
    localparam int LAYER_IDX_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int CNT_W       = $clog2(NUM_LAYERS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [PAT_IDX_W-1:0]   cfg_pat,
    input  logic [LAYER_IDX_W-1:0] cfg_layer,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic                   thr_we,
    input  logic [CNT_W-1:0]       thr_val,
    input  logic                   evt_clear,
    input  logic                   hit_valid,
    input  logic [LAYER_IDX_W-1:0] hit_layer,
    input  logic [ADDR_W-1:0]      hit_addr,
    input  logic                   evt_end,
    output logic                   road_valid,
    input  logic                   road_ready,
    output logic [PAT_IDX_W-1:0]   road_idx,
    output logic                   road_last,
    output logic                   evt_done
);
    import road_pkg::*;

    evt_state_t                              st_q, st_d;
    logic [CNT_W-1:0]                        thr_q;
    logic [NUM_PATTERNS-1:0][NUM_LAYERS-1:0] match;
    logic [NUM_PATTERNS-1:0]                 fire;
    logic                                    open_evt;
    logic                                    hit_ok, end_ok, cfg_ok, thr_ok;
    logic                                    pop, rd_any, rd_last;

    assign open_evt = (st_q == ST_IDLE) || (st_q == ST_COLLECT);
    assign hit_ok   = hit_valid && open_evt && !evt_clear;
    assign end_ok   = evt_end && open_evt && !evt_clear;
    assign cfg_ok   = cfg_we && (st_q == ST_IDLE) && !evt_clear;
    assign thr_ok   = thr_we && (st_q == ST_IDLE) && !evt_clear
                      && (thr_val >= CNT_W'(1))
                      && (thr_val <= CNT_W'(NUM_LAYERS));
    assign pop      = road_valid && road_ready;

    // Programmable layer threshold, reset to all layers.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= CNT_W'(NUM_LAYERS);
        else if (thr_ok) thr_q <= thr_val;
    end

    // Next-state selection of the event sequencer.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (end_ok) st_d = ST_EVAL;
                        else if (hit_ok) st_d = ST_COLLECT;
            ST_COLLECT: if (end_ok) st_d = ST_EVAL;
            ST_EVAL:    st_d = (|fire) ? ST_READ : ST_DONE;
            ST_READ:    if (pop && rd_last) st_d = ST_DONE;
            ST_DONE:    st_d = ST_DONE;
            default:    st_d = ST_IDLE;
        endcase
        if (evt_clear) st_d = ST_IDLE;
    end

    // Event sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    road_bank #(
        .NUM_LAYERS  (NUM_LAYERS),
        .NUM_PATTERNS(NUM_PATTERNS),
        .ADDR_W      (ADDR_W),
        .PAT_IDX_W   (PAT_IDX_W),
        .LAYER_IDX_W (LAYER_IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_ok),
        .wr_pat   (cfg_pat),
        .wr_layer (cfg_layer),
        .wr_addr  (cfg_addr),
        .hit_en   (hit_ok),
        .hit_layer(hit_layer),
        .hit_addr (hit_addr),
        .clr      (evt_clear),
        .match_o  (match)
    );

    road_vote #(
        .NUM_LAYERS  (NUM_LAYERS),
        .NUM_PATTERNS(NUM_PATTERNS),
        .CNT_W       (CNT_W)
    ) u_vote (
        .match_i(match),
        .thr    (thr_q),
        .fire_o (fire)
    );

    road_readout #(
        .NUM_PATTERNS(NUM_PATTERNS),
        .PAT_IDX_W   (PAT_IDX_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (evt_clear),
        .load    (st_q == ST_EVAL),
        .load_vec(fire),
        .pop     (pop),
        .any_o   (rd_any),
        .last_o  (rd_last),
        .idx_o   (road_idx)
    );

    assign road_valid = (st_q == ST_READ) && rd_any;
    assign road_last  = road_valid && rd_last;
    assign evt_done   = (st_q == ST_DONE);

endmodule

// File: rtl/road_matcher_chk.sv
// Protocol checker for road_matcher, attached through bind.
// Assumes: connected to the top's ports and its threshold register.
module road_matcher_chk #(
    parameter int NUM_LAYERS = 6,
    parameter int PAT_IDX_W  = 6,
    parameter int CNT_W      = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 evt_clear,
    input logic                 road_valid,
    input logic                 road_ready,
    input logic [PAT_IDX_W-1:0] road_idx,
    input logic                 road_last,
    input logic                 evt_done,
    input logic [CNT_W-1:0]     thr_q
);

    assert_hold_while_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (road_valid && !road_ready && !evt_clear) |=> (road_valid && $stable(road_idx)));

    assert_ascending_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (road_valid && road_ready && !road_last && !evt_clear)
        |=> (road_valid && (road_idx > $past(road_idx))));

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (road_valid && road_ready && road_last && !evt_clear) |=> evt_done);

    assert_valid_done_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(road_valid && evt_done));

    assert_clear_abandons_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clear |=> (!road_valid && !evt_done));

    assert_threshold_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q >= CNT_W'(1)) && (thr_q <= CNT_W'(NUM_LAYERS)));

endmodule

bind road_matcher road_matcher_chk #(
    .NUM_LAYERS(NUM_LAYERS),
    .PAT_IDX_W (PAT_IDX_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_clear (evt_clear),
    .road_valid(road_valid),
    .road_ready(road_ready),
    .road_idx  (road_idx),
    .road_last (road_last),
    .evt_done  (evt_done),
    .thr_q     (thr_q)
);

// File: tb/tb_road_matcher.sv
`timescale 1ns/1ps
// Self-checking bench: small configuration, reference model of the
// stored words, sticky matches and vote, near-exhaustive event sweep.
module tb_road_matcher;
    localparam int L  = 3;
    localparam int P  = 8;
    localparam int A  = 3;
    localparam int PW = 3;
    localparam int LW = 2;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [PW-1:0] cfg_pat = '0;
    logic [LW-1:0] cfg_layer = '0;
    logic [A-1:0]  cfg_addr = '0;
    logic          thr_we = 1'b0;
    logic [CW-1:0] thr_val = '0;
    logic          evt_clear = 1'b0;
    logic          hit_valid = 1'b0;
    logic [LW-1:0] hit_layer = '0;
    logic [A-1:0]  hit_addr = '0;
    logic          evt_end = 1'b0;
    logic          road_valid;
    logic          road_ready = 1'b0;
    logic [PW-1:0] road_idx;
    logic          road_last;
    logic          evt_done;

    int checks = 0;
    int failures = 0;
    int stm [P][L];
    bit lat [P][L];
    int thr_m = L;

    always #2 clk = ~clk;   // 250 MHz

    road_matcher #(.NUM_LAYERS(L), .NUM_PATTERNS(P), .ADDR_W(A)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pat(cfg_pat),
        .cfg_layer(cfg_layer), .cfg_addr(cfg_addr), .thr_we(thr_we),
        .thr_val(thr_val), .evt_clear(evt_clear), .hit_valid(hit_valid),
        .hit_layer(hit_layer), .hit_addr(hit_addr), .evt_end(evt_end),
        .road_valid(road_valid), .road_ready(road_ready), .road_idx(road_idx),
        .road_last(road_last), .evt_done(evt_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pattern write; the model follows only when the write is expected to land.
    task automatic load(input int p, input int l, input int a, input bit lands);
        cfg_we = 1'b1; cfg_pat = PW'(p); cfg_layer = LW'(l); cfg_addr = A'(a);
        @(negedge clk);
        cfg_we = 1'b0;
        if (lands) stm[p][l] = a;
    endtask

    task automatic set_thr(input int v, input bit lands);
        thr_we = 1'b1; thr_val = CW'(v);
        @(negedge clk);
        thr_we = 1'b0;
        if (lands) thr_m = v;
    endtask

    // One hit, optionally together with end of event.
    task automatic hit(input int l, input int a, input bit endf);
        hit_valid = 1'b1; hit_layer = LW'(l); hit_addr = A'(a); evt_end = endf;
        @(negedge clk);
        hit_valid = 1'b0; evt_end = 1'b0;
        for (int p = 0; p < P; p++)
            if (l < L && stm[p][l] == a) lat[p][l] = 1'b1;
    endtask

    task automatic pulse_end();
        evt_end = 1'b1;
        @(negedge clk);
        evt_end = 1'b0;
    endtask

    task automatic clear();
        evt_clear = 1'b1;
        @(negedge clk);
        evt_clear = 1'b0;
        for (int p = 0; p < P; p++)
            for (int l = 0; l < L; l++) lat[p][l] = 1'b0;
    endtask

    // Drain the readout and compare against the model (R4, R5, R6).
    task automatic readout(input string tag, input int mode);
        int exp_list[$];
        int k = 0;
        bit done = 0;
        for (int p = 0; p < P; p++) begin
            int c = 0;
            for (int l = 0; l < L; l++) c += lat[p][l];
            if (c >= thr_m) exp_list.push_back(p);
        end
        for (int c = 0; c < 300 && !done; c++) begin
            @(negedge clk);
            road_ready = 1'b0;
            if (evt_done) done = 1;
            else if (road_valid) begin
                if (((c + mode) % 3) != 0) begin
                    road_ready = 1'b1;
                    if (k < exp_list.size()) begin
                        chk(road_idx == PW'(exp_list[k]), {"R4 R5 road index ", tag},
                            road_idx, exp_list[k]);
                        chk(road_last == (k == exp_list.size() - 1), {"R5 last flag ", tag},
                            road_last, k == exp_list.size() - 1);
                    end else
                        chk(0, {"R6 unexpected road ", tag}, road_idx, -1);
                    k++;
                end
            end
        end
        road_ready = 1'b0;
        chk(done, {"R6 done raised ", tag}, done, 1);
        chk(k == exp_list.size(), {"R4 fired count ", tag}, k, exp_list.size());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!road_valid, "R10 reset road_valid", road_valid, 0);
        chk(!evt_done, "R10 reset evt_done", evt_done, 0);

        // R8: bank load while idle; each address hits one pattern per layer
        for (int p = 0; p < P; p++)
            for (int l = 0; l < L; l++) load(p, l, (p * 3 + l * 5 + 1) % 8, 1);

        // R10: threshold resets to L; empty event gives done, no roads
        pulse_end();
        readout("reset empty", 0);
        clear();

        // R1 R2 R3 R4: sweep thresholds and events
        for (int t = 1; t <= L; t++) begin
            set_thr(t, 1);
            for (int ev = 0; ev < 10; ev++) begin
                hit(3, ev % 8, 0);  // R1: out-of-range layer matches nothing
                for (int l = 0; l < L; l++)
                    for (int j = 0; j < 3; j++)
                        hit(l, (ev * 5 + l * 3 + j * 3 + t * 7) % 8,
                            (l == L - 1) && (j == 2));  // R3: last hit with end
                readout($sformatf("sweep t%0d e%0d", t, ev), ev);
                clear();
            end
        end

        // R7: out-of-range write (0) ignored; threshold stays 2
        set_thr(2, 1);
        set_thr(0, 0);
        hit(0, stm[4][0], 0);
        hit(1, stm[4][1], 0);
        hit(2, stm[6][2], 1);
        readout("thr zero ignored", 1);
        clear();

        // R7 R8: writes during an event ignored
        set_thr(3, 1);
        hit(0, stm[2][0], 0);
        set_thr(1, 0);
        load(2, 1, stm[5][1], 0);
        hit(1, stm[5][1], 0);
        hit(2, stm[2][2], 1);
        readout("writes in event", 2);
        clear();

        // R9: clear in mid-readout
        set_thr(1, 1);
        hit(0, stm[1][0], 0);
        hit(1, stm[3][1], 0);
        hit(2, stm[6][2], 1);
        for (int c = 0; c < 10 && !road_valid; c++) @(negedge clk);
        chk(road_valid && road_idx == PW'(1), "R9 first road before clear", road_idx, 1);
        road_ready = 1'b1;
        @(negedge clk);
        road_ready = 1'b0;
        clear();
        chk(!road_valid, "R9 valid dropped by clear", road_valid, 0);
        chk(!evt_done, "R9 done dropped by clear", evt_done, 0);
        pulse_end();
        readout("after clear", 0);   // R2 R9: latches rearmed, no road
        clear();

        // R9: clear wins over a same-cycle hit
        evt_clear = 1'b1; hit_valid = 1'b1; hit_layer = '0; hit_addr = A'(stm[0][0]);
        @(negedge clk);
        evt_clear = 1'b0; hit_valid = 1'b0;
        pulse_end();
        readout("clear with hit", 0);
        clear();

        // R2: sticky across non-matching hits, repeated hits harmless
        set_thr(2, 1);
        hit(0, stm[7][0], 0);
        hit(0, stm[7][0], 0);
        hit(0, stm[3][0], 0);
        hit(1, stm[7][1], 0);
        hit(1, stm[0][1], 1);
        readout("sticky", 1);
        clear();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule